// File: doc/BRIEF.md
# Banked DRAM Command Scheduler

This block sits between a memory request source and a DRAM channel. Each incoming read or write carries a physical address and a tag. The address is decoded into a DIMM, rank and bank, and the request is placed in that bank's own queue. With two DIMMs, two ranks per DIMM and eight banks per rank, there are 32 queues.

Each cycle, the scheduler picks at most one queue whose head request is allowed to go out and issues it on the shared command bus. A request is allowed once its bank has recovered from its previous command and the bus timing permits it. The bus timing covers bus occupancy, the extra gap between reads to different ranks, and the turnaround from a read to a write. Candidate queues are served in round-robin order. A completion carrying the request's tag and direction returns a fixed number of cycles after issue.

The source is back-pressured per queue, so a full queue stalls only requests aimed at that bank. Every timing figure, the queue depth and the address field positions are parameters.

Top module: `dram_bank_sched`

## Requirements
- R1: The queue index is {addr[12], addr[11], addr[10:8]}, that is {DIMM, rank, bank} with the bank in the low three bits. No other address bit affects which queue is chosen. The index of the issued request appears on `cmd_queue`.
- R2: Each queue holds QDEPTH requests. While the queue addressed by `req_addr` is full, `req_ready` is low and a presented request is not taken.
- R3: Requests to the same queue are issued in the order they were accepted.
- R4: Two commands to the same queue are at least 11 cycles apart.
- R5: Any two consecutive commands on the bus are at least 2 cycles apart.
- R6: A read that follows a read to a different rank waits at least 3 cycles after it. The rank is {addr[12], addr[11]}, the upper two bits of the queue index.
- R7: A write that follows a read waits at least 4 cycles after it. A command that follows a write has no extra gap beyond R5.
- R8: Among the eligible queues, the grant goes to the first one found when searching upward, with wrap-around, from the queue after the one granted last.
- R9: An idle scheduler issues an accepted request in the cycle after it is accepted.
- R10: Exactly 12 cycles after a command, `cpl_valid` pulses for one cycle with that command's tag and read/write flag.
- R11: During and straight after reset, no command or completion is presented and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target queue has room; a request is taken when this and `req_valid` are both high |
| req_addr | input | 32 | Physical address of the request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_tag | input | 8 | Request identifier |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_wr | output | 1 | Direction of the issued command |
| cmd_queue | output | 5 | Queue index {DIMM, rank, bank} of the issued command |
| cmd_tag | output | 8 | Tag of the issued command |
| cpl_valid | output | 1 | Completion present |
| cpl_wr | output | 1 | 1 = write acknowledge, 0 = read return |
| cpl_tag | output | 8 | Tag of the completed request |

## Verification
The bench builds the block with a queue depth of 4 and keeps every timing figure and address position at its default. The small depth lets a single queue be driven to full and drained again within one bank-recovery window. This exposes the exact cycles in which `req_ready` falls and rises, and it checks the ordering of six queued tags. With the 32-queue default decode, each queue can be swept once with scrambled row, controller and offset bits. The rank, turnaround, bus and round-robin gaps are then measured as exact cycle distances between issued commands.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic {
      OP_RD = 1'b0,
      OP_WR = 1'b1
   } dbs_op_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/dbs_queue.sv
module dbs_queue #(
   parameter int DEPTH = 12,
   parameter int W     = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_p, wr_p;
   logic [CW-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign head  = mem[rd_p];

   always_ff @(posedge clk) begin
      if (push) mem[wr_p] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_p <= '0;
         wr_p <= '0;
         cnt  <= '0;
      end else begin
         if (push) wr_p <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
         if (pop)  rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/dbs_rr_arb.sv
module dbs_rr_arb #(
   parameter int N = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   output logic                 gnt_valid,
   output logic [$clog2(N)-1:0] gnt_idx
);
   localparam int IW = $clog2(N);

   logic [IW-1:0] ptr;

   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int o = N - 1; o >= 0; o--) begin
         if (req[ptr + IW'(o)]) begin
            gnt_valid = 1'b1;
            gnt_idx   = ptr + IW'(o);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr <= '0;
      else if (gnt_valid) ptr <= gnt_idx + 1'b1;
   end
endmodule

// File: rtl/dbs_timing.sv
module dbs_timing #(
   parameter int NQ         = 32,
   parameter int BANK_BITS  = 3,
   parameter int T_BANK     = 11,
   parameter int T_BUS      = 2,
   parameter int T_RANK_GAP = 1,
   parameter int T_RD_WR    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  issue,
   input  logic [$clog2(NQ)-1:0] issue_q,
   input  logic                  issue_wr,
   input  logic [NQ-1:0]         head_wr,
   output logic [NQ-1:0]         elig
);
   localparam int QW   = $clog2(NQ);
   localparam int RKW  = QW - BANK_BITS;
   localparam int SMAX = T_BUS + T_RANK_GAP + T_RD_WR;
   localparam int CW   = $clog2(SMAX + 1);
   localparam int BTW  = $clog2(T_BANK + 1);
   localparam logic [CW-1:0] TH_BUS  = CW'(T_BUS - 1);
   localparam logic [CW-1:0] TH_RANK = CW'(T_BUS + T_RANK_GAP - 1);
   localparam logic [CW-1:0] TH_RW   = CW'(T_BUS + T_RD_WR - 1);

   logic [CW-1:0]  since;
   logic           seen, last_rd;
   logic [RKW-1:0] last_rank;
   logic           bus_ok, rank_hold, rw_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since     <= '0;
         seen      <= 1'b0;
         last_rd   <= 1'b0;
         last_rank <= '0;
      end else if (issue) begin
         since     <= '0;
         seen      <= 1'b1;
         last_rd   <= (issue_wr == dbs_pkg::OP_RD);
         last_rank <= issue_q[QW-1:BANK_BITS];
      end else if (since != CW'(SMAX)) begin
         since <= since + 1'b1;
      end
   end

   assign bus_ok    = !seen || (since >= TH_BUS);
   assign rank_hold = seen && last_rd && (since < TH_RANK);
   assign rw_hold   = seen && last_rd && (since < TH_RW);

   for (genvar q = 0; q < NQ; q++) begin : g_bank
      localparam logic [QW-1:0]  QID = QW'(q);
      localparam logic [RKW-1:0] RK  = QID[QW-1:BANK_BITS];
      logic [BTW-1:0] busy;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     busy <= '0;
         else if (issue && issue_q == QID) busy <= BTW'(T_BANK - 1);
         else if (busy != '0)            busy <= busy - 1'b1;
      end

      assign elig[q] = (busy == '0) && bus_ok
                     && !(rw_hold && head_wr[q])
                     && !(rank_hold && !head_wr[q] && (RK != last_rank));
   end
endmodule

// File: rtl/dbs_cmpl_pipe.sv
module dbs_cmpl_pipe #(
   parameter int LAT = 12,
   parameter int W   = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   logic         v [LAT];
   logic [W-1:0] d [LAT];

   for (genvar s = 0; s < LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v[0] <= 1'b0;
            else        v[0] <= in_valid;
         end
         always_ff @(posedge clk) d[0] <= in_data;
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v[s] <= 1'b0;
            else        v[s] <= v[s-1];
         end
         always_ff @(posedge clk) d[s] <= d[s-1];
      end
   end

   assign out_valid = v[LAT-1];
   assign out_data  = d[LAT-1];
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched #(
   parameter int ADDR_W     = 32,
   parameter int TAG_W      = 8,
   parameter int N_BANKS    = 8,
   parameter int N_RANKS    = 2,
   parameter int N_DIMMS    = 2,
   parameter int BANK_LSB   = 8,
   parameter int RANK_LSB   = 11,
   parameter int DIMM_LSB   = 12,
   parameter int QDEPTH     = 12,
   parameter int T_BANK     = 11,
   parameter int T_BUS      = 2,
   parameter int T_RANK_GAP = 1,
   parameter int T_RD_WR    = 2,
   parameter int T_CMPL     = 12,
   localparam int BB = $clog2(N_BANKS),
   localparam int RB = $clog2(N_RANKS),
   localparam int DB = $clog2(N_DIMMS),
   localparam int QW = BB + RB + DB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wr,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              cmd_valid,
   output logic              cmd_wr,
   output logic [QW-1:0]     cmd_queue,
   output logic [TAG_W-1:0]  cmd_tag,
   output logic              cpl_valid,
   output logic              cpl_wr,
   output logic [TAG_W-1:0]  cpl_tag
);
   localparam int NQ = 1 << QW;
   localparam int EW = TAG_W + 1;

   if (!dbs_pkg::is_pow2(N_BANKS) || !dbs_pkg::is_pow2(N_RANKS) || !dbs_pkg::is_pow2(N_DIMMS)
       || N_BANKS < 2 || N_RANKS < 2 || N_DIMMS < 2)
      $error("bank, rank and DIMM counts must be powers of two, each at least 2");
   if (BANK_LSB + BB > ADDR_W || RANK_LSB + RB > ADDR_W || DIMM_LSB + DB > ADDR_W)
      $error("address field lies outside the address width");
   if (QDEPTH < 2 || T_BANK < 1 || T_BUS < 1 || T_CMPL < 1)
      $error("queue depth and timing parameters out of range");

   logic [QW-1:0] dec_q;
   logic [NQ-1:0] q_empty, q_full, q_push, q_pop, head_wr, elig;
   logic [EW-1:0] heads [NQ];
   logic          gnt_valid;
   logic [QW-1:0] gnt_idx;

   assign dec_q = {req_addr[DIMM_LSB +: DB], req_addr[RANK_LSB +: RB], req_addr[BANK_LSB +: BB]};
   assign req_ready = !q_full[dec_q];

   for (genvar q = 0; q < NQ; q++) begin : g_q
      assign q_push[q]  = req_valid && req_ready && (dec_q == QW'(q));
      assign q_pop[q]   = gnt_valid && (gnt_idx == QW'(q));
      assign head_wr[q] = heads[q][EW-1];

      dbs_queue #(.DEPTH(QDEPTH), .W(EW)) fifo_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (q_push[q]),
         .push_data({req_wr, req_tag}),
         .pop      (q_pop[q]),
         .head     (heads[q]),
         .empty    (q_empty[q]),
         .full     (q_full[q])
      );
   end

   dbs_timing #(
      .NQ(NQ), .BANK_BITS(BB), .T_BANK(T_BANK), .T_BUS(T_BUS),
      .T_RANK_GAP(T_RANK_GAP), .T_RD_WR(T_RD_WR)
   ) timing_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue   (gnt_valid),
      .issue_q (gnt_idx),
      .issue_wr(cmd_wr),
      .head_wr (head_wr),
      .elig    (elig)
   );

   dbs_rr_arb #(.N(NQ)) arb_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (~q_empty & elig),
      .gnt_valid(gnt_valid),
      .gnt_idx  (gnt_idx)
   );

   assign cmd_valid = gnt_valid;
   assign cmd_queue = gnt_idx;
   assign cmd_wr    = heads[gnt_idx][EW-1];
   assign cmd_tag   = heads[gnt_idx][TAG_W-1:0];

   dbs_cmpl_pipe #(.LAT(T_CMPL), .W(EW)) cpl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (gnt_valid),
      .in_data  ({cmd_wr, cmd_tag}),
      .out_valid(cpl_valid),
      .out_data ({cpl_wr, cpl_tag})
   );
endmodule

// File: rtl/dram_bank_sched_chk.sv
module dram_bank_sched_chk #(
   parameter int QW         = 5,
   parameter int BANK_BITS  = 3,
   parameter int T_BUS      = 2,
   parameter int T_RANK_GAP = 1,
   parameter int T_RD_WR    = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_wr,
   input logic [QW-1:0] cmd_queue,
   input logic          cpl_valid,
   input logic          req_ready
);
   logic [7:0]          since;
   logic                seen, last_rd;
   logic [QW-1:0]       last_q;
   logic [7:0]          outst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since   <= '0;
         seen    <= 1'b0;
         last_rd <= 1'b0;
         last_q  <= '0;
         outst   <= '0;
      end else begin
         if (cmd_valid) begin
            since   <= '0;
            seen    <= 1'b1;
            last_rd <= !cmd_wr;
            last_q  <= cmd_queue;
         end else if (since != 8'hFF) begin
            since <= since + 1'b1;
         end
         outst <= outst + 8'(cmd_valid) - 8'(cpl_valid);
      end
   end

   p_bus_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && seen) |-> (int'(since) + 1 >= T_BUS));

   p_rank_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_wr && seen && last_rd
       && (cmd_queue[QW-1:BANK_BITS] != last_q[QW-1:BANK_BITS]))
      |-> (int'(since) + 1 >= T_BUS + T_RANK_GAP));

   p_rd_wr_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_wr && seen && last_rd) |-> (int'(since) + 1 >= T_BUS + T_RD_WR));

   p_cpl_backed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> (outst != 8'd0));

   p_quiet_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen && outst == 8'd0) |-> (!cpl_valid && req_ready));
endmodule

bind dram_bank_sched dram_bank_sched_chk #(
   .QW(QW), .BANK_BITS(BB), .T_BUS(T_BUS), .T_RANK_GAP(T_RANK_GAP), .T_RD_WR(T_RD_WR)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_wr   (cmd_wr),
   .cmd_queue(cmd_queue),
   .cpl_valid(cpl_valid),
   .req_ready(req_ready)
);

// File: tb/dram_bank_sched_tb_top.sv
`timescale 1ns/1ps
module dram_bank_sched_tb_top;
   localparam int QD   = 4;
   localparam int TBK  = 11;
   localparam int TCP  = 12;
   localparam int NLOG = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_wr = 1'b0;
   logic [7:0]  req_tag = '0;
   logic        cmd_valid, cmd_wr, cpl_valid, cpl_wr;
   logic [4:0]  cmd_queue;
   logic [7:0]  cmd_tag, cpl_tag;

   int cyc = 0, checks = 0, failures = 0, n_sent = 0, nt = 1;
   bit done = 0;

   int         ct [NLOG];
   int         cq [NLOG];
   logic [7:0] ctg [NLOG];
   logic       cw [NLOG];
   int         n_cmd = 0;
   int         pdue [NLOG];
   logic [7:0] ptag [NLOG];
   logic       pwr  [NLOG];
   int         p_h = 0, p_n = 0;

   always #2 clk = ~clk;

   dram_bank_sched #(.QDEPTH(QD)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wr(req_wr), .req_tag(req_tag),
      .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_queue(cmd_queue), .cmd_tag(cmd_tag),
      .cpl_valid(cpl_valid), .cpl_wr(cpl_wr), .cpl_tag(cpl_tag)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
      end
   endtask

   // monitor: log commands and compare completions against issue time + TCP
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (p_h < p_n && pdue[p_h] == cyc) begin
            chk(cpl_valid && cpl_tag == ptag[p_h] && cpl_wr == pwr[p_h], "R10 completion",
                cpl_valid ? int'(cpl_tag) : -1, int'(ptag[p_h]));
            p_h++;
         end else if (cpl_valid) begin
            chk(1'b0, "R10 unexpected completion", int'(cpl_tag), -1);
         end
         if (cmd_valid && n_cmd < NLOG) begin
            ct[n_cmd] = cyc; cq[n_cmd] = int'(cmd_queue);
            ctg[n_cmd] = cmd_tag; cw[n_cmd] = cmd_wr;
            n_cmd++;
            pdue[p_n] = cyc + TCP; ptag[p_n] = cmd_tag; pwr[p_n] = cmd_wr;
            p_n++;
         end
      end
   end

   function automatic int find_cmd(input logic [7:0] t);
      for (int i = 0; i < n_cmd; i++) if (ctg[i] == t) return i;
      return -1;
   endfunction

   task automatic send(input int q, input logic wr, input logic [31:0] extra,
                       output logic [7:0] tag, output int acc);
      @(negedge clk);
      tag       = 8'(nt); nt++;
      req_valid = 1'b1;
      req_addr  = (extra & ~(32'h1F << 8)) | (32'(q) << 8);
      req_wr    = wr;
      req_tag   = tag;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      acc = cyc;
      n_sent++;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pair(input int q1, input logic w1, input int q2, input logic w2,
                       input int gap, input string rq);
      logic [7:0] t1, t2;
      int a1, a2, i1, i2;
      send(q1, w1, 32'h0003_4040, t1, a1);
      send(q2, w2, 32'h0007_80C0, t2, a2);
      idle(30);
      i1 = find_cmd(t1); i2 = find_cmd(t2);
      if (i1 < 0 || i2 < 0) chk(1'b0, rq, i2, 0);
      else begin
         chk(ct[i1] == a1 + 1, "R9 immediate issue", ct[i1], a1 + 1);
         chk(ct[i2] - ct[i1] == gap, rq, ct[i2] - ct[i1], gap);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      done = 1;
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      logic [7:0] t, bt0;
      int a, k0, idx;
      bit r;

      // R11: reset state
      repeat (3) @(negedge clk);
      chk(!cmd_valid && !cpl_valid, "R11 outputs quiet in reset", int'(cmd_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !cmd_valid && !cpl_valid, "R11 after reset", int'(req_ready), 1);

      // R1/R9: sweep every queue with scrambled row, controller and offset bits
      for (int q = 0; q < 32; q++) begin
         send(q, q[0], 32'hA5A5_0000 ^ (32'(q) * 32'h0101_2345), t, a);
         idle(4);
         idx = find_cmd(t);
         chk(idx >= 0 && cq[idx] == q, "R1 queue decode", idx >= 0 ? cq[idx] : -1, q);
         chk(idx >= 0 && ct[idx] == a + 1, "R9 issue next cycle", idx >= 0 ? ct[idx] : -1, a + 1);
      end
      idle(30);

      pair(5, 1'b0, 5, 1'b0, TBK, "R4 bank busy");
      pair(1, 1'b0, 2, 1'b0, 2, "R5 bus occupancy");
      pair(1, 1'b0, 9, 1'b0, 3, "R6 rank gap same DIMM");
      pair(1, 1'b0, 17, 1'b0, 3, "R6 rank gap other DIMM");
      pair(1, 1'b0, 2, 1'b1, 4, "R7 read to write");
      pair(1, 1'b0, 9, 1'b1, 4, "R7 read to write other rank");
      pair(1, 1'b1, 2, 1'b0, 2, "R7 write then read no extra");
      pair(1, 1'b1, 9, 1'b1, 2, "R7 write then write other rank");

      // R8: round robin, 6 then 7 and 2 pending -> 7 before 2
      begin
         logic [7:0] ta, tb, tc;
         int aa, ab, ac, ia, ib, ic;
         send(6, 1'b0, 32'h0, ta, aa);
         send(2, 1'b0, 32'h0, tb, ab);
         send(7, 1'b0, 32'h0, tc, ac);
         idle(30);
         ia = find_cmd(ta); ib = find_cmd(tb); ic = find_cmd(tc);
         chk(ia >= 0 && ct[ia] == aa + 1, "R8 first grant", ia >= 0 ? ct[ia] : -1, aa + 1);
         chk(ic >= 0 && ct[ic] == aa + 3, "R8 queue 7 after 6", ic >= 0 ? ct[ic] : -1, aa + 3);
         chk(ib >= 0 && ct[ib] == aa + 5, "R8 queue 2 after wrap", ib >= 0 ? ct[ib] : -1, aa + 5);
      end

      // R2/R3: fill queue 3 while its bank recovers
      @(negedge clk);
      k0 = cyc;
      bt0 = 8'(nt);
      req_valid = 1'b1;
      req_addr  = 32'(3) << 8;
      req_wr    = 1'b0;
      req_tag   = bt0;
      for (int i = 0; i <= TBK + 2; i++) begin
         #1;
         chk(req_ready == ((i <= QD) || (i >= TBK + 2)), "R2 back-pressure",
             int'(req_ready), int'((i <= QD) || (i >= TBK + 2)));
         r = req_ready;
         @(posedge clk); #1;
         if (r) begin req_tag = req_tag + 8'd1; nt++; n_sent++; end
         @(negedge clk);
      end
      req_valid = 1'b0;
      idle(90);
      for (int j = 0; j <= QD + 1; j++) begin
         idx = find_cmd(bt0 + 8'(j));
         chk(idx >= 0 && ct[idx] == k0 + 1 + TBK * j && cq[idx] == 3, "R3 order and spacing",
             idx >= 0 ? ct[idx] : -1, k0 + 1 + TBK * j);
      end
      chk(find_cmd(bt0 + 8'(QD + 2)) < 0, "R2 refused request not queued",
          find_cmd(bt0 + 8'(QD + 2)), -1);

      idle(20);
      chk(n_cmd == n_sent, "R3 every accepted request issued", n_cmd, n_sent);
      chk(p_h == p_n, "R10 every command completed", p_h, p_n);
      done = 1;
      finish_run();
   end
endmodule